// File: doc/BRIEF.md
# Segment Address Translator with Bounds and Rights Checking

This block turns a segmented virtual reference (a segment number plus a displacement) into a physical address. It holds a small table with one descriptor per segment. A descriptor has four fields: a residency flag, three permission bits, a segment length and a physical base. Each request names a segment, a displacement and the kind of access wanted. One clock later the block returns a result strobe together with either a translated address or exactly one fault code.

Three things can stop a translation. The segment may not be resident. The displacement may fall outside the segment. The access kind may not be permitted. When more than one applies, a fixed priority picks the code that is reported. The table is loaded through a single-entry write port that commits on the clock edge.

A two-state controller sequences the result. The states are CT_IDLE (no result on the outputs) and CT_DELIVER (a result is presented). The transitions are: CT_IDLE to CT_DELIVER when a request arrives; CT_DELIVER stays in CT_DELIVER when another request arrives; CT_DELIVER to CT_IDLE when no request arrives; CT_IDLE stays in CT_IDLE otherwise.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held, out_valid is 0. Reset clears the residency flag of every descriptor, so a request issued after reset and before any table write reports the missing fault.
- R2: out_valid is 1 in the cycle after a cycle in which req_valid was 1. It is 0 in the cycle after a cycle in which req_valid was 0.
- R3: When no fault applies, out_fault is 0 and out_paddr equals (base + displacement) modulo 2^24. The displacement is zero-extended before the addition.
- R4: A descriptor whose residency flag is 0 yields out_fault = 1 (missing), whatever its other fields and the access kind.
- R5: For a resident descriptor, a displacement greater than or equal to the length yields out_fault = 2 (overflow). Displacement length-1 is in bounds. A length of 0 makes every displacement overflow.
- R6: Permission bits are bit 0 read, bit 1 write and bit 2 execute. req_access encodes 0 read, 1 write, 2 execute and 3 reserved. If the permission bit for the requested kind is 0, or the kind is 3, the result is out_fault = 3 (protection), provided no higher-priority fault applies.
- R7: Fault priority is missing, then overflow, then protection. Exactly one code is reported per request.
- R8: Whenever out_fault is nonzero, out_paddr is 0.
- R9: A table write takes effect at the clock edge. A request to the same segment in the same cycle sees the previous descriptor, and a request in the following cycle sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 4 | Segment number of the request |
| req_disp | input | 16 | Displacement within the segment |
| req_access | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| wr_en | input | 1 | Descriptor write strobe |
| wr_seg | input | 4 | Descriptor index to write |
| wr_present | input | 1 | Residency flag to store |
| wr_rights | input | 3 | Permission bits to store (0 read, 1 write, 2 execute) |
| wr_len | input | 17 | Segment length to store |
| wr_base | input | 24 | Physical base to store |
| out_valid | output | 1 | Result strobe, one cycle after a request |
| out_fault | output | 2 | 0 none, 1 missing, 2 overflow, 3 protection |
| out_paddr | output | 24 | Translated physical address, 0 on a fault |

## Verification
The bench loads all sixteen descriptors and sweeps each one over every access kind and over displacements at 0, length-1, length, length+1, the middle and the top of the range. It computes the expected code and address arithmetically. A comparator that used greater-than instead of greater-or-equal would accept displacement equal to the length. A design whose priority order was wrong would report protection or overflow on an absent segment, or protection on a zero-length segment. A base addition that was not truncated, or not zero-extended, would give the wrong address on the segment placed near the top of physical space. A write that bypassed to a same-cycle read would show the new descriptor one cycle early.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_MISSING  = 2'd1,
        FLT_OVERFLOW = 2'd2,
        FLT_PROTECT  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    localparam int RIGHTS_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W  = 4,
    parameter int LEN_W  = 17,
    parameter int PA_W   = 24,
    parameter int RGT_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  logic             wr_present,
    input  logic [RGT_W-1:0] wr_rights,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [SEG_W-1:0] rd_idx,
    output logic             rd_present,
    output logic [RGT_W-1:0] rd_rights,
    output logic [LEN_W-1:0] rd_len,
    output logic [PA_W-1:0]  rd_base
);
    localparam int NSEG = 1 << SEG_W;

    logic [NSEG-1:0]  present_q;
    logic [RGT_W-1:0] rights_q [NSEG];
    logic [LEN_W-1:0] len_q    [NSEG];
    logic [PA_W-1:0]  base_q   [NSEG];

    // Residency flags are the only reset state; other fields are don't-care while absent.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            present_q <= '0;
        end else if (wr_en) begin
            present_q[wr_idx] <= wr_present;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rights_q[wr_idx] <= wr_rights;
            len_q[wr_idx]    <= wr_len;
            base_q[wr_idx]   <= wr_base;
        end
    end

    // Read is combinational from stored state: a same-cycle write is not forwarded.
    assign rd_present = present_q[rd_idx];
    assign rd_rights  = rights_q[rd_idx];
    assign rd_len     = len_q[rd_idx];
    assign rd_base    = base_q[rd_idx];

    // R9: a write lands in the addressed descriptor at the next edge
    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (present_q[$past(wr_idx)] == $past(wr_present))
               && (base_q[$past(wr_idx)] == $past(wr_base))
               && (len_q[$past(wr_idx)] == $past(wr_len)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int DISP_W = 16,
    parameter int LEN_W  = 17,
    parameter int PA_W   = 24,
    parameter int RGT_W  = 3
) (
    input  logic              present,
    input  logic [RGT_W-1:0]  rights,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic [PA_W-1:0]   base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        access,
    output logic [1:0]        fault,
    output logic [PA_W-1:0]   paddr
);
    localparam int NKIND = 3;

    logic             beyond;
    logic [NKIND-1:0] kind_ok;
    logic             allowed;
    fault_e           cause;

    // Equal-to-length counts as out of bounds: valid offsets are 0 .. len-1.
    assign beyond = {{(LEN_W-DISP_W){1'b0}}, disp} >= seg_len;

    // One permission decode per defined access kind; the reserved kind matches none.
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        assign kind_ok[k] = (access == 2'(k)) && rights[k];
    end
    assign allowed = |kind_ok;

    always_comb begin
        if (!present) begin
            cause = FLT_MISSING;
        end else if (beyond) begin
            cause = FLT_OVERFLOW;
        end else if (!allowed) begin
            cause = FLT_PROTECT;
        end else begin
            cause = FLT_NONE;
        end
    end

    assign fault = cause;
    assign paddr = (cause == FLT_NONE) ? (base + {{(PA_W-DISP_W){1'b0}}, disp}) : '0;

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl #(
    parameter int PA_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      fault_in,
    input  logic [PA_W-1:0] paddr_in,
    output logic            out_valid,
    output logic [1:0]      out_fault,
    output logic [PA_W-1:0] out_paddr
);
    typedef enum logic {
        CT_IDLE    = 1'b0,
        CT_DELIVER = 1'b1
    } ct_state_e;

    ct_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CT_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE:    if (req_valid)  state_d = CT_DELIVER;
            CT_DELIVER: if (!req_valid) state_d = CT_IDLE;
            default:    state_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_fault <= '0;
            out_paddr <= '0;
        end else if (req_valid) begin
            out_fault <= fault_in;
            out_paddr <= paddr_in;
        end else begin
            out_fault <= '0;
            out_paddr <= '0;
        end
    end

    assign out_valid = (state_q == CT_DELIVER);

    // R2: result strobe tracks the request one cycle later
    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    p_quiet_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);
    // R8: a faulted result never carries an address
    p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault != 2'd0) |-> out_paddr == '0);

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int SEG_W  = 4,
    parameter int DISP_W = 16,
    parameter int PA_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [1:0]        req_access,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  logic              wr_present,
    input  logic [2:0]        wr_rights,
    input  logic [DISP_W:0]   wr_len,
    input  logic [PA_W-1:0]   wr_base,
    output logic              out_valid,
    output logic [1:0]        out_fault,
    output logic [PA_W-1:0]   out_paddr
);
    import seg_xlate_pkg::*;

    localparam int LEN_W = DISP_W + 1;

    logic                rd_present;
    logic [RIGHTS_W-1:0] rd_rights;
    logic [LEN_W-1:0]    rd_len;
    logic [PA_W-1:0]     rd_base;
    logic [1:0]          chk_fault;
    logic [PA_W-1:0]     chk_paddr;

    seg_table #(
        .SEG_W (SEG_W),
        .LEN_W (LEN_W),
        .PA_W  (PA_W),
        .RGT_W (RIGHTS_W)
    ) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_seg),
        .wr_present (wr_present),
        .wr_rights  (wr_rights),
        .wr_len     (wr_len),
        .wr_base    (wr_base),
        .rd_idx     (req_seg),
        .rd_present (rd_present),
        .rd_rights  (rd_rights),
        .rd_len     (rd_len),
        .rd_base    (rd_base)
    );

    seg_check #(
        .DISP_W (DISP_W),
        .LEN_W  (LEN_W),
        .PA_W   (PA_W),
        .RGT_W  (RIGHTS_W)
    ) check_i (
        .present (rd_present),
        .rights  (rd_rights),
        .seg_len (rd_len),
        .base    (rd_base),
        .disp    (req_disp),
        .access  (req_access),
        .fault   (chk_fault),
        .paddr   (chk_paddr)
    );

    seg_xlate_ctrl #(
        .PA_W (PA_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .fault_in  (chk_fault),
        .paddr_in  (chk_paddr),
        .out_valid (out_valid),
        .out_fault (out_fault),
        .out_paddr (out_paddr)
    );

    // R4: an absent descriptor always reports the missing code
    p_missing_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rd_present) |=> out_fault == 2'd1);
    // R5: resident but out of bounds reports overflow
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_present && ({1'b0, req_disp} >= rd_len)) |=> out_fault == 2'd2);
    // R6: the reserved access kind on an in-bounds resident segment is a protection fault
    p_reserved_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rd_present && ({1'b0, req_disp} < rd_len) && req_access == 2'd3)
            |=> out_fault == 2'd3);
    // R1: no result strobe while reset is applied
    always_comb begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (!out_valid);
        end
    end

endmodule

// File: tb/seg_xlate_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_disp = '0;
    logic [1:0]  req_access = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_seg = '0;
    logic        wr_present = 1'b0;
    logic [2:0]  wr_rights = '0;
    logic [16:0] wr_len = '0;
    logic [23:0] wr_base = '0;
    logic        out_valid;
    logic [1:0]  out_fault;
    logic [23:0] out_paddr;

    int n_checks = 0;
    int n_bad = 0;

    int m_pres   [16];
    int m_rights [16];
    int m_len    [16];
    int m_base   [16];

    always #2.5 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_seg(req_seg), .req_disp(req_disp), .req_access(req_access),
        .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present), .wr_rights(wr_rights),
        .wr_len(wr_len), .wr_base(wr_base),
        .out_valid(out_valid), .out_fault(out_fault), .out_paddr(out_paddr)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_fault(input int s, input int d, input int a);
        if (m_pres[s] == 0) return 1;
        if (d >= m_len[s]) return 2;
        if (a == 3 || ((m_rights[s] >> a) & 1) == 0) return 3;
        return 0;
    endfunction

    function automatic string tag_of(input int s, input int d, input int a, input int f);
        bit multi;
        multi = (f == 1 && (d >= m_len[s] || a == 3)) || (f == 2 && (a == 3 || ((m_rights[s] >> a) & 1) == 0));
        if (multi) return "R7 priority";
        case (f)
            0: return "R3 translate";
            1: return "R4 missing";
            2: return "R5 bounds";
            default: return "R6 rights";
        endcase
    endfunction

    // Called just after a falling edge; returns just after a falling edge.
    task automatic write_entry(input int s, input int p, input int r, input int l, input int b);
        wr_en = 1'b1; wr_seg = 4'(s); wr_present = 1'(p); wr_rights = 3'(r);
        wr_len = 17'(l); wr_base = 24'(b);
        @(negedge clk);
        wr_en = 1'b0;
        m_pres[s] = p; m_rights[s] = r; m_len[s] = l; m_base[s] = b;
    endtask

    task automatic apply(input int s, input int d, input int a);
        int f;
        int pa;
        f  = exp_fault(s, d, a);
        pa = (f == 0) ? ((m_base[s] + d) & 24'hFFFFFF) : 0;
        req_valid = 1'b1; req_seg = 4'(s); req_disp = 16'(d); req_access = 2'(a);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 strobe after request", int'(out_valid), 1);
        check(tag_of(s, d, a, f), int'(out_fault), f);
        check((f == 0) ? "R3 address" : "R8 address zero on fault", int'(out_paddr), pa);
        @(negedge clk);
        check("R2 strobe low when idle", int'(out_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_pres[i] = 0; m_rights[i] = 0; m_len[i] = 0; m_base[i] = 0;
        end
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid low after reset", int'(out_valid), 0);

        // R1: cleared table reports missing for every segment
        for (int s = 0; s < 16; s++) begin
            apply(s, 0, 0);
        end

        // Load descriptors
        for (int s = 0; s < 16; s++) begin
            int p, l, b;
            p = (s != 5 && s != 12) ? 1 : 0;
            if (s == 0) l = 0;
            else if (s == 1 || s == 15) l = 65536;
            else l = ((s * 4099) & 16'hFFFF) + 1;
            b = (s == 15) ? 24'hFFFFF0 : ((s * 24'h123457) & 24'hFFFFFF);
            write_entry(s, p, s % 8, l, b);
        end

        // Sweep displacements around each bound for every access kind
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 7; k++) begin
                int d;
                case (k)
                    0: d = 0;
                    1: d = m_len[s] - 1;
                    2: d = m_len[s];
                    3: d = m_len[s] + 1;
                    4: d = m_len[s] / 2;
                    5: d = 16'hFFFF;
                    default: d = 1;
                endcase
                d = d & 16'hFFFF;
                for (int a = 0; a < 4; a++) begin
                    apply(s, d, a);
                end
            end
        end

        // R9: same-cycle write and request to segment 3 sees the old descriptor
        begin
            int f_old, pa_old;
            f_old  = exp_fault(3, 10, 0);
            pa_old = (f_old == 0) ? ((m_base[3] + 10) & 24'hFFFFFF) : 0;
            wr_en = 1'b1; wr_seg = 4'd3; wr_present = 1'b1; wr_rights = 3'b001;
            wr_len = 17'd20; wr_base = 24'h0ABC00;
            req_valid = 1'b1; req_seg = 4'd3; req_disp = 16'd10; req_access = 2'd0;
            @(negedge clk);
            wr_en = 1'b0; req_valid = 1'b0;
            check("R9 same-cycle fault old entry", int'(out_fault), f_old);
            check("R9 same-cycle addr old entry", int'(out_paddr), pa_old);
            m_pres[3] = 1; m_rights[3] = 1; m_len[3] = 20; m_base[3] = 24'h0ABC00;
            @(negedge clk);
            apply(3, 10, 0);
            apply(3, 19, 0);
            apply(3, 20, 0);
            apply(3, 10, 1);
        end

        // R4: removing residency overrides everything
        write_entry(1, 0, 7, 65536, 0);
        apply(1, 0, 0);
        apply(1, 16'hFFFF, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_bad);
        $finish;
    end

endmodule